// File: doc/BRIEF.md
# Byte-Pair Long Write Controller

This block joins pairs of 8-bit table writes into single 16-bit program-memory word writes. A byte write to an even address only loads a holding register. A byte write to the next odd address starts one word-program operation. The odd byte and the held even byte travel together to the program interface as one word, and that interface has a request/acknowledge handshake.

While a word write is in flight, the requester is stalled. The stall lasts until the programming engine has acknowledged the word and an external, interrupt-style terminate event has arrived. These two can come in either order. A long-write enable bit gates every byte write. Software can set the bit, and only reset clears it. A read port returns any byte of the program array, so each write can be checked afterwards. The array is modelled inside the block as two byte lanes, and it reads as erased (all ones) after reset.

Top module: `lw_pair_ctrl`

## Requirements
- R1: With the enable set and no write in flight, a byte write to an even address (address bit 0 = 0) loads the holding register only, and does not raise the stall or the program request.
- R2: With the enable set and no write in flight, a byte write to an odd address raises the program request in the next cycle. The word address is the byte address with bit 0 cleared. The word data has the odd byte in bits 15:8 and the held byte in bits 7:0. Request, address and data stay unchanged until the acknowledge.
- R3: The stall rises in the cycle after the odd write and stays high until release. Byte writes presented while the stall is high are ignored.
- R4: The stall drops in the cycle after both the acknowledge and the terminate event have been seen. They may arrive in either order or in the same cycle. The terminate event and the acknowledge have no effect while idle.
- R5: While the enable bit is clear, byte writes are ignored: the holding register is not loaded and nothing is launched.
- R6: A set pulse sets the enable bit from the next cycle on, and a write in the same cycle as the set pulse sees the old value. Nothing but reset clears the enable bit.
- R7: A second even-address write with no odd write in between replaces the held byte.
- R8: The read port returns the byte at any byte address. The even byte of a word comes from its low half and the odd byte from its high half. Unwritten bytes read 8'hFF. The array takes the word on the cycle it is acknowledged.
- R9: Reset leaves the stall and request low, the enable clear, the holding register at 8'hFF and the whole array erased to 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lwen_set_i | input | 1 | Pulse that sets the long-write enable |
| lwen_o | output | 1 | Current long-write enable |
| wr_valid_i | input | 1 | Byte write strobe |
| wr_addr_i | input | ADDR_W | Byte write address |
| wr_data_i | input | 8 | Byte write data |
| stall_o | output | 1 | Requester stall |
| term_i | input | 1 | Terminate event |
| pgm_req_o | output | 1 | Word program request |
| pgm_addr_o | output | ADDR_W | Word program address (bit 0 always 0) |
| pgm_data_o | output | 16 | Word program data |
| pgm_ack_i | input | 1 | Word program acknowledge |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | 8 | Read byte data |

## Verification
The assertions check on every cycle that:
- a request only exists under the stall;
- the request address is even;
- request, address and data hold until the acknowledge;
- no launch happens without the enable;
- the stall never drops without a terminate;
- the enable never falls outside reset.

Only the bench scenarios can show how bytes pair up across the holding register. These cover ignored writes while disabled or stalled, an overwritten held byte, every ordering of acknowledge and terminate, and the contents of the array read back through the read port.

// File: rtl/lwpc_pkg.sv
package lwpc_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] ERASED_BYTE = '1;

  typedef struct packed {
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } word_t;
endpackage

// File: rtl/lwpc_hold.sv
module lwpc_hold
  import lwpc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_o <= ERASED_BYTE;
    else if (load_i) hold_o <= data_i;
  end
endmodule

// File: rtl/lwpc_seq.sv
module lwpc_seq
  import lwpc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lwen_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [BYTE_W-1:0] hold_i,
  input  logic              term_i,
  input  logic              ack_i,
  output logic              load_hold_o,
  output logic              stall_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o,
  output logic              commit_o
);
  logic              busy_q, acked_q, termd_q;
  logic [ADDR_W-1:0] addr_q;
  word_t             data_q;
  logic              accept, launch, ack_done, term_done, release_w;

  assign accept      = wr_valid_i && lwen_i && !busy_q;
  assign load_hold_o = accept && !wr_addr_i[0];
  assign launch      = accept && wr_addr_i[0];
  assign req_o       = busy_q && !acked_q;
  assign commit_o    = req_o && ack_i;
  assign ack_done    = acked_q || commit_o;
  assign term_done   = termd_q || term_i;
  assign release_w   = busy_q && ack_done && term_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      acked_q <= 1'b0;
      termd_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      acked_q <= 1'b0;
      termd_q <= 1'b0;
      addr_q  <= {wr_addr_i[ADDR_W-1:1], 1'b0};
      data_q  <= '{hi: wr_data_i, lo: hold_i};
    end else if (release_w) begin
      busy_q  <= 1'b0;
      acked_q <= 1'b0;
      termd_q <= 1'b0;
    end else if (busy_q) begin
      acked_q <= ack_done;
      termd_q <= term_done;
    end
  end

  assign stall_o = busy_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  assert_req_under_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> stall_o);
  assert_addr_even_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !addr_o[0]);
  assert_req_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(data_o)));
  assert_launch_needs_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(lwen_i));
  assert_release_needs_term_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(term_i) || $past(termd_q)));
endmodule

// File: rtl/lwpc_mem.sv
module lwpc_mem
  import lwpc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-2:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int WORDS = 1 << (ADDR_W - 1);

  logic [1:0][BYTE_W-1:0] lane_rd;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [BYTE_W-1:0] arr [WORDS];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < WORDS; i++) arr[i] <= ERASED_BYTE;
      end else if (we_i) begin
        arr[waddr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
      end
    end
    assign lane_rd[g] = arr[raddr_i[ADDR_W-1:1]];
  end

  assign rdata_o = lane_rd[raddr_i[0]];
endmodule

// File: rtl/lw_pair_ctrl.sv
module lw_pair_ctrl
  import lwpc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lwen_set_i,
  output logic              lwen_o,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              stall_o,
  input  logic              term_i,
  output logic              pgm_req_o,
  output logic [ADDR_W-1:0] pgm_addr_o,
  output logic [15:0]       pgm_data_o,
  input  logic              pgm_ack_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic              lwen_q, load_hold, commit;
  logic [BYTE_W-1:0] hold;

  // sticky: only reset clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lwen_q <= 1'b0;
    else if (lwen_set_i) lwen_q <= 1'b1;
  end
  assign lwen_o = lwen_q;

  lwpc_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_hold),
    .data_i (wr_data_i),
    .hold_o (hold)
  );

  lwpc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lwen_i      (lwen_q),
    .wr_valid_i  (wr_valid_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .hold_i      (hold),
    .term_i      (term_i),
    .ack_i       (pgm_ack_i),
    .load_hold_o (load_hold),
    .stall_o     (stall_o),
    .req_o       (pgm_req_o),
    .addr_o      (pgm_addr_o),
    .data_o      (pgm_data_o),
    .commit_o    (commit)
  );

  lwpc_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (commit),
    .waddr_i (pgm_addr_o[ADDR_W-1:1]),
    .wdata_i (pgm_data_o),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assert_lwen_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(lwen_q));
  assert_no_load_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_hold |-> lwen_q);
endmodule

// File: tb/lw_pair_ctrl_test.sv
`timescale 1ns/1ps
module lw_pair_ctrl_test;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lwen_set = 0, wr_valid = 0, term = 0, ack = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic lwen, stall, req, rd_dummy;
  logic [AW-1:0] paddr;
  logic [15:0] pdata;
  logic [7:0] rd_data;

  int checks = 0, errors = 0, cycles = 0;
  bit cmp_on = 0;

  // reference model state
  bit m_en = 0, m_busy = 0, m_acked = 0, m_termd = 0;
  logic [7:0] m_hold = 8'hFF;
  logic [AW-1:0] m_addr = '0;
  logic [15:0] m_data = '0;
  logic [7:0] m_mem [int];

  always #2 clk = ~clk;

  lw_pair_ctrl #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .lwen_set_i(lwen_set), .lwen_o(lwen),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .stall_o(stall), .term_i(term), .pgm_req_o(req), .pgm_addr_o(paddr),
    .pgm_data_o(pdata), .pgm_ack_i(ack), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );
  assign rd_dummy = 1'b0;

  function automatic logic [7:0] mrd(int a);
    return m_mem.exists(a) ? m_mem[a] : 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_busy = 0; m_acked = 0; m_termd = 0; m_hold = 8'hFF;
      m_mem.delete();
    end else begin
      if (m_busy) begin
        bit a, t;
        a = m_acked || ack;
        t = m_termd || term;
        if (!m_acked && ack) begin
          m_mem[int'(m_addr)] = m_data[7:0];
          m_mem[int'(m_addr) + 1] = m_data[15:8];
        end
        if (a && t) begin m_busy = 0; m_acked = 0; m_termd = 0; end
        else begin m_acked = a; m_termd = t; end
      end else if (wr_valid && m_en) begin
        if (!wr_addr[0]) m_hold = wr_data;
        else begin
          m_busy = 1; m_acked = 0; m_termd = 0;
          m_addr = {wr_addr[AW-1:1], 1'b0};
          m_data = {wr_data, m_hold};
        end
      end
      if (lwen_set) m_en = 1;
    end
  end

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic compare();
    if (!cmp_on) return;
    check("R3 stall", int'(stall), int'(m_busy));
    check("R2 req", int'(req), int'(m_busy && !m_acked));
    if (m_busy && !m_acked) begin
      check("R2 addr", int'(paddr), int'(m_addr));
      check("R2 data", int'(pdata), int'(m_data));
    end
    check("R6 enable", int'(lwen), int'(m_en));
    check("R8 read", int'(rd_data), int'(mrd(int'(rd_addr))));
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    wr_valid = 0; lwen_set = 0; ack = 0; term = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_valid = 1; wr_addr = a; wr_data = d; tick();
  endtask

  task automatic pulse(input bit do_ack, input bit do_term);
    ack = do_ack; term = do_term; tick();
  endtask

  task automatic rd_chk(string r, input logic [AW-1:0] a, input logic [7:0] exp);
    rd_addr = a; #0.5;
    check(r, int'(rd_data), int'(exp));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 stall", int'(stall), 0);
    check("R9 req", int'(req), 0);
    check("R9 enable", int'(lwen), 0);
    check("R9 read erased", int'(rd_data), 8'hFF);
    rst_n = 1; cmp_on = 1;
    tick();

    // R5 writes ignored while disabled
    wr(8'h00, 8'h5A);
    wr(8'h01, 8'h33);
    check("R5 no launch", int'(stall), 0);
    rd_chk("R5 mem untouched", 8'h01, 8'hFF);

    // R6 write with set pulse sees old enable
    lwen_set = 1; wr_valid = 1; wr_addr = 8'h03; wr_data = 8'h77; tick();
    check("R6 same-cycle write ignored", int'(stall), 0);
    check("R6 enable now set", int'(lwen), 1);

    // R2 odd write with reset hold byte, ack then term
    wr(8'h01, 8'hC3);
    check("R2 launch addr", int'(paddr), 8'h00);
    check("R2 launch data", int'(pdata), 16'hC3FF);
    check("R3 stall raised", int'(stall), 1);
    tick();
    pulse(1, 0);
    check("R4 still stalled after ack", int'(stall), 1);
    tick(); tick();
    pulse(0, 1);
    check("R4 released after term", int'(stall), 0);
    rd_chk("R5 ignored even left hold erased", 8'h00, 8'hFF);
    rd_chk("R8 odd byte", 8'h01, 8'hC3);

    // R1 even loads only; ack+term same cycle
    wr(8'h10, 8'h11);
    check("R1 even no stall", int'(stall), 0);
    check("R1 even no req", int'(req), 0);
    wr(8'h11, 8'h22);
    pulse(1, 1);
    check("R4 same-cycle release", int'(stall), 0);
    rd_chk("R8 low half", 8'h10, 8'h11);
    rd_chk("R8 high half", 8'h11, 8'h22);

    // term before ack
    wr(8'h20, 8'hA0);
    wr(8'h21, 8'hA1);
    pulse(0, 1);
    check("R4 term alone holds stall", int'(stall), 1);
    tick();
    pulse(1, 0);
    check("R4 release after late ack", int'(stall), 0);

    // R7 second even overwrites
    wr(8'h30, 8'h01);
    wr(8'h30, 8'h02);
    wr(8'h31, 8'h03);
    // R3 writes during stall ignored
    wr(8'h40, 8'hEE);
    wr(8'h41, 8'hDD);
    pulse(1, 1);
    rd_chk("R7 overwritten hold", 8'h30, 8'h02);
    rd_chk("R3 stalled write dropped", 8'h41, 8'hFF);
    wr(8'h51, 8'h55);
    check("R3 hold not loaded in stall", int'(pdata), 16'h5502);
    pulse(1, 1);

    // R4 ack/term while idle ignored
    pulse(1, 1);
    check("R4 idle pulses no stall", int'(stall), 0);

    // top of array
    wr(8'hFE, 8'h9C);
    wr(8'hFF, 8'h9D);
    pulse(1, 1);
    rd_chk("R8 top low", 8'hFE, 8'h9C);
    rd_chk("R8 top high", 8'hFF, 8'h9D);

    // R9 reset mid-run clears enable and erases
    wr(8'h60, 8'h12);
    wr(8'h61, 8'h34);
    cmp_on = 0; rst_n = 0;
    @(negedge clk);
    check("R9 reset drops stall", int'(stall), 0);
    check("R6 only reset clears enable", int'(lwen), 0);
    rd_chk("R9 array erased", 8'h10, 8'hFF);
    rst_n = 1; cmp_on = 1;
    tick();
    wr(8'h01, 8'h44);
    check("R5 disabled after reset", int'(stall), 0);
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule